// File: doc/BRIEF.md
# Group Interrupt and Shutdown Controller

This block sits between a small set of host control lines and a bank of converter groups that share open-drain OK lines. It accepts N active-low interrupt inputs plus two global shutdown inputs (a mains-fail line and a soft-reset line). It then decides, group by group, whether that group's OK line must be pulled low. It also tells an external programming sequencer which groups need to be loaded again. The sequencer reports back with a per-group completion pulse, and the block keeps one programmed-status bit per group.

Each interrupt channel is set up in one of two ways. As an inhibit, it holds off any set of groups chosen by a mask while it is low, and the groups come back on when it goes high. As a hot-swap trigger, it acts only on the group with its own index. Its falling edge asks for that group to be programmed. Its rising edge forces the group off and drops its programmed status. A global shutdown forces every group off, clears all status bits and asks for the run-time counter to be saved. When the shutdown ends, every group is programmed again, and a group turns on only if its auto-on bit is set.

Every input is resynchronised and debounced before any edge or level is used.

Top module: `grp_irq_shutdown`

## Requirements
- R1: After reset every bit of `ok_pd_o` is 1, `prog_stat_o` is 0, and no strobe (`prog_req_o`, `clr_stat_o`, `save_cnt_o`) is active.
- R2: Every input passes through a two-flop synchroniser and a debounce filter. A level counts only after the synchronised value has differed from the filtered value for `DEB_CYC` consecutive cycles. A shorter pulse has no effect on any output.
- R3: A channel with `cfg_trig_i[n]`=0 is an inhibit. While it is low, every group g with `cfg_mask_i[n*N+g]`=1 has `ok_pd_o[g]`=1. Unmasked groups are unaffected, and on release the masked groups return to their earlier state.
- R4: A channel with `cfg_trig_i[n]`=1 is a trigger for group n only and never acts as an inhibit. Its filtered falling edge gives a one-cycle pulse on `prog_req_o[n]`.
- R5: A `prog_done_i[g]` pulse outside a global shutdown sets `prog_stat_o[g]`. It releases the group's OK line only when `cfg_autoon_i[g]`=1; otherwise the group stays pulled low.
- R6: The filtered rising edge of a trigger channel n sets `ok_pd_o[n]`, clears `prog_stat_o[n]` and pulses `clr_stat_o[n]` for one cycle.
- R7: When the mains-fail or soft-reset input goes low (shutdown begins), every OK line is pulled low and every status bit is cleared. `clr_stat_o` pulses on all groups and `save_cnt_o` pulses once.
- R8: When both global inputs are high again, `prog_req_o` pulses on all groups. Each group stays off until its own completion pulse, and then follows R5.
- R9: `prog_done_i` has no effect on status or OK lines while a global shutdown is active.
- R10: If a clear (R6 or R7) and `prog_done_i[g]` fall in the same cycle, the clear wins. The group ends off and unprogrammed.
- R11: Programming may complete while an inhibit holds a group. Its status is set, its OK line stays low until the inhibit is released, and then the group turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_ni | input | N | Raw active-low interrupt inputs |
| acfail_ni | input | 1 | Raw active-low mains-fail input |
| sreset_ni | input | 1 | Raw active-low soft-reset input |
| cfg_trig_i | input | N | Per channel: 1 = trigger for same-index group, 0 = inhibit |
| cfg_mask_i | input | N*N | Inhibit masks; bits [n*N +: N] list the groups of channel n |
| cfg_autoon_i | input | N | Per group: turn on automatically after programming |
| prog_done_i | input | N | Per group completion pulse from the sequencer |
| ok_pd_o | output | N | Per group OK-line pull-down enable (1 = pull low) |
| prog_req_o | output | N | Per group programming request pulse |
| clr_stat_o | output | N | Per group status-clear strobe |
| save_cnt_o | output | 1 | Run-time counter save strobe |
| prog_stat_o | output | N | Per group programmed-status bits |

## Verification
The collision of interest is a clear event and a programming completion for the same group in the same cycle. The clear can come from a trigger's rising edge or from the start of a global shutdown. The bench provokes it by following its own reference model of the filter: it watches for the cycle in which the filtered trigger level has just risen, and drives `prog_done_i` for exactly the next edge. It judges the outcome by the status bit staying 0 and the OK line staying pulled low. A second overlap, programming completion during an active inhibit, is driven the same way and judged at the release of the inhibit.

// File: rtl/gisc_pkg.sv
package gisc_pkg;
  localparam int unsigned GISC_N_DEF   = 4;
  localparam int unsigned GISC_DEB_DEF = 4;

  // Width of a counter that must reach values up to n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gisc_filt.sv
module gisc_filt
  import gisc_pkg::*;
#(
  parameter int unsigned DEB_CYC = GISC_DEB_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = cnt_width(DEB_CYC);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYC - 1);

  logic          sync1_q, sync2_q, clean_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      clean_q <= 1'b1;
      run_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q != clean_q) begin
        if (run_q == LIM) begin
          clean_q <= sync2_q;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/gisc_inhibit.sv
module gisc_inhibit
  import gisc_pkg::*;
#(
  parameter int unsigned N = GISC_N_DEF
) (
  input  logic [N-1:0]   lvl_ni,
  input  logic [N-1:0]   trig_i,
  input  logic [N*N-1:0] mask_i,
  output logic [N-1:0]   hold_o
);
  function automatic logic [N-1:0] groups_held(input logic [N-1:0] lvl_n,
                                               input logic [N-1:0] trig,
                                               input logic [N*N-1:0] mask);
    logic [N-1:0] acc;
    acc = '0;
    for (int n = 0; n < int'(N); n++) begin
      if (!trig[n] && !lvl_n[n]) acc = acc | mask[n*N +: N];
    end
    return acc;
  endfunction

  assign hold_o = groups_held(lvl_ni, trig_i, mask_i);
endmodule

// File: rtl/gisc_grp_ctrl.sv
module gisc_grp_ctrl
  import gisc_pkg::*;
#(
  parameter int unsigned N = GISC_N_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_ni,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] autoon_i,
  input  logic         glob_act_i,
  input  logic [N-1:0] prog_done_i,
  output logic [N-1:0] grp_off_o,
  output logic [N-1:0] prog_stat_o,
  output logic [N-1:0] prog_req_o,
  output logic [N-1:0] clr_stat_o,
  output logic         save_cnt_o
);
  logic [N-1:0] lvl_q, off_q, stat_q, req_q, clr_q;
  logic         gact_q, save_q;

  logic         glob_on, glob_off;
  logic [N-1:0] trig_fall, trig_rise, clr_now, done_ok;

  assign glob_on   = glob_act_i & ~gact_q;
  assign glob_off  = ~glob_act_i & gact_q;
  assign trig_fall = trig_i & lvl_q & ~lvl_ni;
  assign trig_rise = trig_i & ~lvl_q & lvl_ni;
  assign clr_now   = {N{glob_on}} | trig_rise;
  assign done_ok   = prog_done_i & {N{~glob_act_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '1;
      gact_q <= 1'b0;
      off_q  <= '1;
      stat_q <= '0;
      req_q  <= '0;
      clr_q  <= '0;
      save_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_ni;
      gact_q <= glob_act_i;
      save_q <= glob_on;
      req_q  <= {N{glob_off}} | trig_fall;
      clr_q  <= clr_now;
      for (int g = 0; g < int'(N); g++) begin
        if (clr_now[g]) begin
          off_q[g]  <= 1'b1;
          stat_q[g] <= 1'b0;
        end else if (done_ok[g]) begin
          stat_q[g] <= 1'b1;
          if (autoon_i[g]) off_q[g] <= 1'b0;
        end
      end
    end
  end

  assign grp_off_o   = off_q;
  assign prog_stat_o = stat_q;
  assign prog_req_o  = req_q;
  assign clr_stat_o  = clr_q;
  assign save_cnt_o  = save_q;
endmodule

// File: rtl/grp_irq_shutdown.sv
module grp_irq_shutdown
  import gisc_pkg::*;
#(
  parameter int unsigned N       = GISC_N_DEF,
  parameter int unsigned DEB_CYC = GISC_DEB_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   irq_ni,
  input  logic           acfail_ni,
  input  logic           sreset_ni,
  input  logic [N-1:0]   cfg_trig_i,
  input  logic [N*N-1:0] cfg_mask_i,
  input  logic [N-1:0]   cfg_autoon_i,
  input  logic [N-1:0]   prog_done_i,
  output logic [N-1:0]   ok_pd_o,
  output logic [N-1:0]   prog_req_o,
  output logic [N-1:0]   clr_stat_o,
  output logic           save_cnt_o,
  output logic [N-1:0]   prog_stat_o
);
  localparam int unsigned NIN = N + 2;

  logic [NIN-1:0] raw_n, clean_n;
  logic [N-1:0]   irq_clean_n, inh_hold, grp_off;
  logic           glob_act;

  assign raw_n = {sreset_ni, acfail_ni, irq_ni};

  for (genvar i = 0; i < int'(NIN); i++) begin : g_filt
    gisc_filt #(.DEB_CYC(DEB_CYC)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_n[i]),
      .clean_o(clean_n[i])
    );
  end

  assign irq_clean_n = clean_n[N-1:0];
  assign glob_act    = ~clean_n[N] | ~clean_n[N+1];

  gisc_inhibit #(.N(N)) u_inh (
    .lvl_ni(irq_clean_n),
    .trig_i(cfg_trig_i),
    .mask_i(cfg_mask_i),
    .hold_o(inh_hold)
  );

  gisc_grp_ctrl #(.N(N)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_ni     (irq_clean_n),
    .trig_i     (cfg_trig_i),
    .autoon_i   (cfg_autoon_i),
    .glob_act_i (glob_act),
    .prog_done_i(prog_done_i),
    .grp_off_o  (grp_off),
    .prog_stat_o(prog_stat_o),
    .prog_req_o (prog_req_o),
    .clr_stat_o (clr_stat_o),
    .save_cnt_o (save_cnt_o)
  );

  // Wired-OR of every reason to hold a group off.
  assign ok_pd_o = grp_off | inh_hold | {N{glob_act}};
endmodule

// File: rtl/grp_irq_shutdown_chk.sv
module grp_irq_shutdown_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         glob_act,
  input logic [N-1:0] ok_pd,
  input logic [N-1:0] prog_req,
  input logic [N-1:0] clr_stat,
  input logic         save_cnt,
  input logic [N-1:0] prog_stat,
  input logic [N-1:0] prog_done
);
  p_global_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    glob_act |-> (&ok_pd));

  p_save_clears_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save_cnt |-> (&clr_stat));

  p_save_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save_cnt |=> !save_cnt);

  for (genvar g = 0; g < int'(N); g++) begin : g_grp
    p_clear_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stat[g] |-> (!prog_stat[g] && ok_pd[g]));

    p_stat_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_stat[g]) |-> ($past(prog_done[g]) && !$past(glob_act)));

    p_on_needs_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_pd[g] |-> prog_stat[g]);

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req[g] && !glob_act) |=> !prog_req[g]);
  end
endmodule

bind grp_irq_shutdown grp_irq_shutdown_chk #(.N(N)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .glob_act (glob_act),
  .ok_pd    (ok_pd_o),
  .prog_req (prog_req_o),
  .clr_stat (clr_stat_o),
  .save_cnt (save_cnt_o),
  .prog_stat(prog_stat_o),
  .prog_done(prog_done_i)
);

// File: tb/tb_grp_irq_shutdown.sv
module tb_grp_irq_shutdown;
  localparam int N = 4;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_n = '1;
  logic acf_n = 1'b1, srst_n = 1'b1;
  logic [N-1:0] cfg_trig = 4'b1100;
  logic [N*N-1:0] cfg_mask = {4'b0000, 4'b0000, 4'b1000, 4'b0011};
  logic [N-1:0] cfg_autoon = 4'b1011;
  logic [N-1:0] prog_done = '0;
  logic [N-1:0] ok_pd, prog_req, clr_stat, prog_stat;
  logic save_cnt;

  always #5 clk = ~clk;

  grp_irq_shutdown #(.N(N), .DEB_CYC(DEB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .acfail_ni(acf_n),
    .sreset_ni(srst_n), .cfg_trig_i(cfg_trig), .cfg_mask_i(cfg_mask),
    .cfg_autoon_i(cfg_autoon), .prog_done_i(prog_done), .ok_pd_o(ok_pd),
    .prog_req_o(prog_req), .clr_stat_o(clr_stat), .save_cnt_o(save_cnt),
    .prog_stat_o(prog_stat)
  );

  int checks = 0, failures = 0;
  string phase = "R1";
  bit done = 0;

  // Behavioural reference model, advanced once per rising edge.
  logic [5:0] m_s1 = '1, m_s2 = '1, m_cl = '1, m_clq = '1;
  int m_cnt [6];
  logic [N-1:0] m_goff = '1, m_pst = '0, m_req = '0, m_clr = '0;
  logic m_save = 1'b0;

  always @(posedge clk) begin
    logic [5:0] raw;
    bit gact, gactq, gon, goffev, tf, tr, clr;
    raw = {srst_n, acf_n, irq_n};
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_cl = '1; m_clq = '1;
      for (int i = 0; i < 6; i++) m_cnt[i] = 0;
      m_goff = '1; m_pst = '0; m_req = '0; m_clr = '0; m_save = 0;
    end else begin
      gact = !m_cl[4] || !m_cl[5];
      gactq = !m_clq[4] || !m_clq[5];
      gon = gact && !gactq;
      goffev = !gact && gactq;
      for (int g = 0; g < N; g++) begin
        tf = cfg_trig[g] && m_clq[g] && !m_cl[g];
        tr = cfg_trig[g] && !m_clq[g] && m_cl[g];
        clr = gon || tr;
        m_req[g] = goffev || tf;
        m_clr[g] = clr;
        if (clr) begin
          m_goff[g] = 1; m_pst[g] = 0;
        end else if (prog_done[g] && !gact) begin
          m_pst[g] = 1;
          if (cfg_autoon[g]) m_goff[g] = 0;
        end
      end
      m_save = gon;
      for (int i = 0; i < 6; i++) begin
        m_clq[i] = m_cl[i];
        if (m_s2[i] != m_cl[i]) begin
          if (m_cnt[i] == DEB - 1) begin
            m_cl[i] = m_s2[i]; m_cnt[i] = 0;
          end else m_cnt[i]++;
        end else m_cnt[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = raw[i];
      end
    end
  end

  function automatic logic [N-1:0] exp_ok();
    logic [N-1:0] v;
    v = m_goff;
    if (!m_cl[4] || !m_cl[5]) v = '1;
    for (int n = 0; n < N; n++)
      if (!cfg_trig[n] && !m_cl[n]) v = v | cfg_mask[n*N +: N];
    return v;
  endfunction

  task automatic chk(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", phase, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison with the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("ok_pd", ok_pd, exp_ok());
      chk("prog_req", prog_req, m_req);
      chk("clr_stat", clr_stat, m_clr);
      chk("save_cnt", {3'b0, save_cnt}, {3'b0, m_save});
      chk("prog_stat", prog_stat, m_pst);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done(input logic [N-1:0] v);
    prog_done = v; cyc(1); prog_done = '0;
  endtask

  initial begin
    cyc(3);
    phase = "R1";
    chk("reset ok_pd", ok_pd, 4'b1111);
    chk("reset prog_stat", prog_stat, 4'b0000);
    chk("reset strobes", prog_req | clr_stat, 4'b0000);
    rst_n = 1'b1;
    cyc(3);
    chk("idle ok_pd", ok_pd, 4'b1111);

    phase = "R5";
    pulse_done(4'b1111); cyc(3);
    chk("autoon groups on, group2 held", ok_pd, 4'b0100);
    chk("all programmed", prog_stat, 4'b1111);

    phase = "R2";
    irq_n[0] = 0; cyc(3); irq_n[0] = 1; cyc(12);
    chk("short pulse ignored", ok_pd, 4'b0100);

    phase = "R3";
    irq_n[0] = 0; cyc(12);
    chk("inhibit holds masked groups", ok_pd, 4'b0111);
    irq_n[0] = 1; cyc(12);
    chk("inhibit release restores", ok_pd, 4'b0100);

    phase = "R4";
    irq_n[3] = 0; cyc(12);
    chk("trigger is not an inhibit", ok_pd, 4'b0100);
    pulse_done(4'b1000); cyc(3);
    chk("group3 on after programming", ok_pd, 4'b0100);

    phase = "R6";
    irq_n[3] = 1; cyc(12);
    chk("release forces group3 off", ok_pd, 4'b1100);
    chk("release clears status", prog_stat, 4'b0111);

    phase = "R11";
    irq_n[1] = 0; cyc(12);
    irq_n[3] = 0; cyc(12);
    pulse_done(4'b1000); cyc(3);
    chk("programmed under inhibit", prog_stat, 4'b1111);
    chk("held off by inhibit", ok_pd, 4'b1100);
    irq_n[1] = 1; cyc(12);
    chk("on after inhibit release", ok_pd, 4'b0100);

    phase = "R10";
    irq_n[3] = 1;
    for (int k = 0; k < 40 && !(m_cl[3] && !m_clq[3]); k++) cyc(1);
    pulse_done(4'b1000); cyc(3);
    chk("clear wins status", prog_stat, 4'b0111);
    chk("clear wins ok_pd", ok_pd, 4'b1100);

    phase = "R7";
    acf_n = 0; cyc(12);
    chk("shutdown pulls all", ok_pd, 4'b1111);
    chk("shutdown clears status", prog_stat, 4'b0000);

    phase = "R9";
    pulse_done(4'b1111); cyc(3);
    chk("done ignored in shutdown", prog_stat, 4'b0000);

    phase = "R8";
    acf_n = 1; cyc(12);
    chk("off until programmed", ok_pd, 4'b1111);
    pulse_done(4'b1111); cyc(3);
    chk("autoon after reprogram", ok_pd, 4'b0100);

    phase = "R7";
    srst_n = 0; cyc(5); acf_n = 0; cyc(12);
    chk("overlapping shutdown", ok_pd, 4'b1111);
    phase = "R8";
    srst_n = 1; cyc(12);
    pulse_done(4'b1111); cyc(3);
    chk("still active while one low", prog_stat, 4'b0000);
    acf_n = 1; cyc(12);
    pulse_done(4'b0111); cyc(3);
    chk("partial reprogram", ok_pd, 4'b1100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule